// File: doc/BRIEF.md
# Acknowledged Ethernet Image Packet Transmitter

The block turns a byte stream of image data into Ethernet frames on a 4-bit transmit bus. One pulse on the frame-request input starts a transfer of a given number of image bytes. The block cuts the image into packets of at most `MAX_DATA` data bytes and sends them one at a time. It holds each packet in a local buffer until the receive side reports an acknowledgement carrying that packet's sequence number.

Each frame carries a short payload header: a type byte, a 16-bit sequence number and a 16-bit data length. The image bytes follow, and zero padding is added when the frame would be too short. If no matching acknowledgement arrives within a programmable number of clock cycles, the frame is sent again from the buffer and the source is not read again. The transfer ends after the last packet is acknowledged.

Top module: `ait_tx`

## Requirements
- R1: After reset, `tx_en_o`, `txd_o`, `busy_o` and `src_ready_o` are all 0.
- R2: Each frame starts with seven 0x55 bytes and then one 0xD5 byte. Every byte is sent as two nibbles, low nibble first, one nibble per clock. `tx_en_o` is high for exactly the frame's nibbles, and `txd_o` is 0 while `tx_en_o` is low.
- R3: After the preamble come the `DST_MAC` bytes, the `SRC_MAC` bytes and the `ETH_TYPE` bytes, each most significant byte first. Then come a type byte 0x01 (image data), the sequence number (2 bytes, MSB first), the data length (2 bytes, MSB first) and the data bytes in stream order.
- R4: An image of N bytes is sent as ceil(N/`MAX_DATA`) packets. Every packet except the last carries `MAX_DATA` bytes, and the last carries the remainder.
- R5: If there are fewer than 60 bytes from the destination address through the data, zero bytes are added until there are 60. A frame without preamble is therefore never shorter than 64 bytes.
- R6: A 4-byte FCS follows, least significant byte first. It is the CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, inverted at the end) over the destination address through the padding.
- R7: Between two frames `tx_en_o` stays low for at least 24 clocks (12 byte times).
- R8: A transfer starts only on `start_req_i` while `busy_o` is 0 and `img_bytes_i` is nonzero. A request while busy has no effect.
- R9: The sequence number is 0 for the first packet of each image. It advances only when `ack_valid_i` carries a number equal to it. Acknowledgements with any other number, and any acknowledgement while idle, are ignored.
- R10: Call the first clock with `tx_en_o` low after a frame cycle 0. Cycles 25 to 25+`timeout_i` are the acknowledgement window. If no matching acknowledgement arrives in the window, the same frame is sent again with `tx_en_o` rising in cycle 26+`timeout_i`, and the source is not read for it.
- R11: A matching acknowledgement in cycle 25+`timeout_i` wins over the timeout. One arriving in cycle 26+`timeout_i` is ignored, because the resend has already started.
- R12: `busy_o` is high from an accepted request until the last packet is acknowledged. `src_ready_o` is high only while a packet is being loaded, never while a frame is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_req_i | input | 1 | Frame-request pulse that starts an image transfer |
| img_bytes_i | input | IMG_W | Image size in bytes, sampled with the request |
| timeout_i | input | TMO_W | Acknowledgement wait, in clock cycles |
| src_valid_i | input | 1 | Image byte available |
| src_data_i | input | 8 | Image byte |
| src_ready_o | output | 1 | Byte taken at this clock edge when valid |
| ack_valid_i | input | 1 | Acknowledgement event |
| ack_seq_i | input | 16 | Packet number carried by the acknowledgement |
| busy_o | output | 1 | Transfer in progress |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |

## Verification
The acknowledgement path and the retransmit timer can act in the same clock: a matching acknowledgement can land in exactly the cycle in which the wait count reaches `timeout_i`. The bench measures every cycle from the falling edge of `tx_en_o` and places an acknowledgement on that last waiting cycle. The next frame must then carry the following sequence number and new data. The bench also places an acknowledgement one cycle later. Then the next frame must be an identical resend that rises exactly 26+`timeout_i` cycles after the previous frame ended.

// File: rtl/ait_pkg.sv
package ait_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SEND, ST_WAIT} ait_state_e;

  localparam int PRE_BYTES  = 8;   // preamble + delimiter
  localparam int HDR_END    = 27;  // first data byte index within frame
  localparam int MIN_BODY   = 60;  // dst..pad minimum
  localparam int FCS_BYTES  = 4;
  localparam int IFG_BYTES  = 12;
  localparam logic [7:0] TYPE_DATA = 8'h01;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ait_crc32.sv
module ait_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= ait_pkg::crc32_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ait_pkt_buf.sv
module ait_pkt_buf #(
  parameter int DEPTH = 1500,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ait_frame_gen.sv
module ait_frame_gen #(
  parameter int          MAX_DATA = 1500,
  parameter logic [47:0] DST_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC  = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETH_TYPE = 16'h88B5,
  localparam int LW = $clog2(MAX_DATA + 1),
  localparam int AW = $clog2(MAX_DATA),
  localparam int IW = $clog2(ait_pkg::HDR_END + MAX_DATA + ait_pkg::PRE_BYTES
                             + ait_pkg::MIN_BODY + ait_pkg::FCS_BYTES + ait_pkg::IFG_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [15:0]   seq_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          done_o,
  output logic [3:0]    txd_o,
  output logic          tx_en_o
);
  import ait_pkg::*;

  logic          active_q, phase_q, done_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] hdr_end, body_end, on_end, ifg_end, off_d, off_s, off_f;
  logic [7:0]    cur_byte;
  logic [47:0]   dst_sh, src_sh;
  logic [31:0]   fcs, fcs_sh, crc;
  logic [15:0]   len16;
  logic          last_nib, crc_en;

  assign len16    = 16'(len_i);
  assign hdr_end  = IW'(HDR_END) + IW'(len_i);
  assign body_end = (hdr_end < IW'(PRE_BYTES + MIN_BODY)) ? IW'(PRE_BYTES + MIN_BODY) : hdr_end;
  assign on_end   = body_end + IW'(FCS_BYTES);
  assign ifg_end  = on_end + IW'(IFG_BYTES);
  assign last_nib = active_q && phase_q && (idx_q == ifg_end - IW'(1));

  assign off_d  = idx_q - IW'(8);
  assign off_s  = idx_q - IW'(14);
  assign off_f  = idx_q - body_end;
  assign dst_sh = DST_MAC << {off_d[2:0], 3'b000};
  assign src_sh = SRC_MAC << {off_s[2:0], 3'b000};
  assign fcs    = ~crc;
  assign fcs_sh = fcs >> {off_f[1:0], 3'b000};
  assign rd_addr_o = AW'(idx_q - IW'(HDR_END));

  always_comb begin
    if      (idx_q < IW'(7))        cur_byte = 8'h55;
    else if (idx_q == IW'(7))       cur_byte = 8'hD5;
    else if (idx_q < IW'(14))       cur_byte = dst_sh[47:40];
    else if (idx_q < IW'(20))       cur_byte = src_sh[47:40];
    else if (idx_q == IW'(20))      cur_byte = ETH_TYPE[15:8];
    else if (idx_q == IW'(21))      cur_byte = ETH_TYPE[7:0];
    else if (idx_q == IW'(22))      cur_byte = TYPE_DATA;
    else if (idx_q == IW'(23))      cur_byte = seq_i[15:8];
    else if (idx_q == IW'(24))      cur_byte = seq_i[7:0];
    else if (idx_q == IW'(25))      cur_byte = len16[15:8];
    else if (idx_q == IW'(26))      cur_byte = len16[7:0];
    else if (idx_q < hdr_end)       cur_byte = rd_data_i;
    else if (idx_q < body_end)      cur_byte = 8'h00;
    else if (idx_q < on_end)        cur_byte = fcs_sh[7:0];
    else                            cur_byte = 8'h00;
  end

  assign crc_en = active_q && phase_q && (idx_q >= IW'(PRE_BYTES)) && (idx_q < body_end);

  ait_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (start_i),
    .en_i   (crc_en),
    .byte_i (cur_byte),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_nib;
      if (start_i) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        idx_q    <= '0;
      end else if (active_q) begin
        phase_q <= ~phase_q;
        if (phase_q) idx_q <= idx_q + IW'(1);
        if (last_nib) active_q <= 1'b0;
      end
    end
  end

  assign done_o  = done_q;
  assign tx_en_o = active_q && (idx_q < on_end);
  assign txd_o   = !tx_en_o ? 4'h0 : (phase_q ? cur_byte[7:4] : cur_byte[3:0]);
endmodule

// File: rtl/ait_tx.sv
module ait_tx #(
  parameter int          MAX_DATA = 1500,
  parameter int          IMG_W    = 24,
  parameter int          TMO_W    = 20,
  parameter logic [47:0] DST_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC  = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETH_TYPE = 16'h88B5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_req_i,
  input  logic [IMG_W-1:0] img_bytes_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  output logic             src_ready_o,
  input  logic             ack_valid_i,
  input  logic [15:0]      ack_seq_i,
  output logic             busy_o,
  output logic [3:0]       txd_o,
  output logic             tx_en_o
);
  import ait_pkg::*;

  localparam int LW = $clog2(MAX_DATA + 1);
  localparam int AW = $clog2(MAX_DATA);

  ait_state_e       state_q;
  logic [IMG_W-1:0] rem_q, rem_n;
  logic [LW-1:0]    chunk_q, fill_q;
  logic [15:0]      seq_q;
  logic [TMO_W-1:0] tmr_q;
  logic             take, last_take, accept, tmo, gen_start, gen_done;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;

  function automatic logic [LW-1:0] chunk_of(input logic [IMG_W-1:0] r);
    if (r > IMG_W'(MAX_DATA)) return LW'(MAX_DATA);
    return LW'(r);
  endfunction

  assign take      = (state_q == ST_FILL) && src_valid_i;
  assign last_take = take && (fill_q == chunk_q - LW'(1));
  assign accept    = (state_q == ST_WAIT) && ack_valid_i && (ack_seq_i == seq_q);
  assign tmo       = (state_q == ST_WAIT) && (tmr_q == timeout_i) && !accept;
  assign gen_start = last_take || tmo;
  assign rem_n     = rem_q - IMG_W'(chunk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      chunk_q <= '0;
      fill_q  <= '0;
      seq_q   <= '0;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_req_i && img_bytes_i != '0) begin
          rem_q   <= img_bytes_i;
          chunk_q <= chunk_of(img_bytes_i);
          fill_q  <= '0;
          seq_q   <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (take) begin
          fill_q <= fill_q + LW'(1);
          if (last_take) state_q <= ST_SEND;
        end
        ST_SEND: if (gen_done) begin
          tmr_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (accept) begin
            seq_q   <= seq_q + 16'd1;
            rem_q   <= rem_n;
            chunk_q <= chunk_of(rem_n);
            fill_q  <= '0;
            state_q <= (rem_n == '0) ? ST_IDLE : ST_FILL;
          end else if (tmo) begin
            state_q <= ST_SEND;
          end else begin
            tmr_q <= tmr_q + TMO_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign src_ready_o = (state_q == ST_FILL);

  ait_pkt_buf #(.DEPTH(MAX_DATA), .AW(AW)) u_buf (
    .clk_i   (clk_i),
    .we_i    (take),
    .waddr_i (AW'(fill_q)),
    .wdata_i (src_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  ait_frame_gen #(
    .MAX_DATA (MAX_DATA),
    .DST_MAC  (DST_MAC),
    .SRC_MAC  (SRC_MAC),
    .ETH_TYPE (ETH_TYPE)
  ) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (gen_start),
    .len_i     (chunk_q),
    .seq_i     (seq_q),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .done_o    (gen_done),
    .txd_o     (txd_o),
    .tx_en_o   (tx_en_o)
  );
endmodule

// File: rtl/ait_tx_chk.sv
module ait_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_o,
  input logic [3:0] txd_o,
  input logic       src_ready_o,
  input logic       busy_o
);
  logic [7:0] idle_cnt_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
      seen_q     <= 1'b0;
    end else if (tx_en_o) begin
      idle_cnt_q <= '0;
      seen_q     <= 1'b1;
    end else if (idle_cnt_q != 8'hFF) begin
      idle_cnt_q <= idle_cnt_q + 8'd1;
    end
  end

  a_r2_preamble_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> txd_o == 4'h5);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> txd_o == 4'h0);

  a_r7_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_en_o) && seen_q) |-> idle_cnt_q >= 8'd24);

  a_r12_no_load_on_air: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> !tx_en_o);

  a_r12_busy_covers_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> busy_o);
endmodule

bind ait_tx ait_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_o     (tx_en_o),
  .txd_o       (txd_o),
  .src_ready_o (src_ready_o),
  .busy_o      (busy_o)
);

// File: tb/sim_ait_tx.sv
module sim_ait_tx;
  localparam int CLK_PERIOD = 40;
  localparam int MAXD = 16;
  localparam logic [47:0] DST = 48'h02_11_22_33_44_55;
  localparam logic [47:0] SRC = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [15:0] ETY = 16'h88B5;
  localparam int NV = 5;
  localparam int TV_LEN  [NV] = '{5, 16, 40, 33, 1};
  localparam int TV_NPKT [NV] = '{1, 1, 3, 3, 1};

  logic clk = 0, rst_ni = 0;
  logic start_req = 0, src_valid = 1, ack_valid = 0;
  logic [23:0] img_bytes = '0;
  logic [19:0] timeout = 20'd200;
  logic [7:0]  src_data = '0;
  logic [15:0] ack_seq = '0;
  logic src_ready, busy, tx_en;
  logic [3:0] txd;

  int checks = 0, errors = 0;
  int cyc = 0, fall_cyc = 0, last_gap = 0, frames = 0, nb = 0, flen = 0;
  int src_off = 0, src_id = 0;
  bit took = 0, en_prev = 0, nph = 0, seen = 0;
  logic [3:0] lo = '0;
  logic [7:0] fb [128];

  ait_tx #(.MAX_DATA(MAXD), .IMG_W(24), .TMO_W(20), .DST_MAC(DST), .SRC_MAC(SRC), .ETH_TYPE(ETY)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_req_i(start_req), .img_bytes_i(img_bytes),
    .timeout_i(timeout), .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .ack_valid_i(ack_valid), .ack_seq_i(ack_seq), .busy_o(busy), .txd_o(txd), .tx_en_o(tx_en));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] pat(input int id, input int off);
    return 8'((id * 37 + off * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // image source
  always @(negedge clk) begin
    if (took) src_off++;
    src_data = pat(src_id, src_off);
    took = src_ready && src_valid;
  end

  // frame monitor
  always @(negedge clk) begin
    if (tx_en) begin
      if (!en_prev && seen) begin
        last_gap = cyc - fall_cyc;
        chk(last_gap >= 24, "R7 inter-frame gap", last_gap, 24);
      end
      if (!nph) lo = txd;
      else begin
        if (nb < 128) fb[nb] = {txd, lo};
        nb++;
      end
      nph = ~nph;
    end else if (en_prev) begin
      chk(!nph, "R2 whole bytes", 32'(nph), 0);
      flen = nb; nb = 0; nph = 0; fall_cyc = cyc; seen = 1; frames++;
    end
    en_prev = tx_en;
  end

  task automatic wait_frame();
    int prev = frames;
    do begin @(negedge clk); #1; end while (frames == prev);
  endtask

  task automatic ack_at(input int k, input int seq);
    repeat (k) @(negedge clk);
    ack_valid = 1; ack_seq = 16'(seq);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic start_img(input int len, input int id);
    @(negedge clk);
    src_id = id; src_off = 0;
    img_bytes = 24'(len); start_req = 1;
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic check_frame(input int seq, input int len, input int id, input int off0);
    int body = (27 + len < 68) ? 68 : 27 + len;
    bit ok;
    logic [31:0] c;
    chk(flen == body + 4, "R5 frame length", flen, body + 4);
    ok = 1;
    for (int i = 0; i < 7; i++) if (fb[i] != 8'h55) ok = 0;
    chk(ok && fb[7] == 8'hD5, "R2 preamble/SFD", fb[7], 8'hD5);
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (fb[8+i]  != DST[8*(5-i) +: 8]) ok = 0;
      if (fb[14+i] != SRC[8*(5-i) +: 8]) ok = 0;
    end
    chk(ok && {fb[20], fb[21]} == ETY, "R3 addresses/ethertype", {fb[20], fb[21]}, ETY);
    chk(fb[22] == 8'h01, "R3 type byte", fb[22], 8'h01);
    chk({fb[23], fb[24]} == 16'(seq), "R9 sequence number", {fb[23], fb[24]}, seq);
    chk({fb[25], fb[26]} == 16'(len), "R4 length field", {fb[25], fb[26]}, len);
    ok = 1;
    for (int j = 0; j < len; j++) if (fb[27+j] != pat(id, off0 + j)) ok = 0;
    chk(ok, "R3 data bytes", 32'(off0), 32'(off0));
    ok = 1;
    for (int j = 27 + len; j < body; j++) if (fb[j] != 8'h00) ok = 0;
    chk(ok, "R5 zero padding", 32'(body), 32'(body));
    c = 32'hFFFFFFFF;
    for (int i = 8; i < flen && i < 128; i++)
      for (int b = 0; b < 8; b++) c = (c[0] ^ fb[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    chk(c == 32'hDEBB20E3, "R6 FCS residue", c, 32'hDEBB20E3);
  endtask

  task automatic run_image(input int len, input int id, input int npkt);
    int rem = len, off = 0, seq = 0, f0;
    f0 = frames;
    start_img(len, id);
    chk(busy == 1'b1, "R12 busy after request", 32'(busy), 1);
    while (rem > 0) begin
      int ch = (rem > MAXD) ? MAXD : rem;
      wait_frame();
      check_frame(seq, ch, id, off);
      ack_at(30, seq);
      rem -= ch; off += ch; seq++;
    end
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R12 idle after last ack", 32'(busy), 0);
    chk(src_off == len, "R4 bytes consumed", src_off, len);
    chk(frames - f0 == npkt, "R4 packet count", frames - f0, npkt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_en == 0 && txd == 0 && busy == 0 && src_ready == 0, "R1 reset outputs",
        {tx_en, txd, busy, src_ready}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    // R9 ack while idle, R8 zero-length request: no activity
    f0 = frames;
    ack_at(2, 0);
    start_img(0, 1);
    repeat (100) @(negedge clk);
    chk(frames == f0 && busy == 0, "R9/R8 idle ignores ack and empty request", frames - f0, 0);

    // table of transfers
    for (int v = 0; v < NV; v++) run_image(TV_LEN[v], v + 2, TV_NPKT[v]);

    // directed: wrong ack, timeout resend, busy request, collision, late ack
    timeout = 20'd10;
    start_img(20, 9);
    wait_frame();
    check_frame(0, 16, 9, 0);
    repeat (3) @(negedge clk);
    img_bytes = 24'd5; start_req = 1;      // R8 request while busy
    @(negedge clk);
    start_req = 0;
    repeat (24) @(negedge clk);
    ack_valid = 1; ack_seq = 16'd5;        // R9 mismatched number, cycle 28
    @(negedge clk);
    ack_valid = 0;
    wait_frame();
    check_frame(0, 16, 9, 0);
    chk(last_gap == 36, "R10 resend start cycle", last_gap, 36);
    chk(src_off == 16, "R10/R8 no source read on resend", src_off, 16);
    ack_at(35, 0);                          // R11 same cycle as timeout
    wait_frame();
    check_frame(1, 4, 9, 16);
    chk(last_gap > 36, "R11 ack won over timeout", last_gap, 37);
    ack_at(36, 1);                          // R11 one cycle late
    wait_frame();
    check_frame(1, 4, 9, 16);
    chk(last_gap == 36, "R11 late ack ignored", last_gap, 36);
    ack_at(30, 1);
    repeat (4) @(negedge clk);
    chk(busy == 0 && src_off == 20, "R12 transfer ends after last ack", src_off, 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule